// File: doc/BRIEF.md
# Bus-Mapped SPI Master with Runtime Clock Polarity

This block is an SPI master that sits on an 8-bit processor bus and is reached through two register addresses. With the address bit low, a bus write queues a byte for transmission, and a bus read returns the byte that was received during the most recent completed transfer. With the address bit high, a bus write sets the clock polarity, and a bus read returns that polarity together with a busy flag. The serial clock is not generated by a divider. It is the bus phase clock, inverted or passed through according to the polarity bit, so the block supports SPI modes 0 and 2.

All logic runs on the system clock `clk_i`. The phase clock `phi_i` is sampled on that clock, and its edges are detected there. A queued byte is loaded into the shift register on the first falling edge of `phi_i` after the write. Each following rising edge shifts out one bit, most significant bit first, and captures one bit of MISO. A polarity write wipes the whole transfer state, so software must set the polarity before it writes data. Chip-select generation is left to the surrounding system.

Top module: `spi_bus_master`

## Requirements
- R1: After reset the polarity bit is 0, `sck_o` equals `phi_i`, `busy_o` is 0, and a data-register read returns 0x00.
- R2: A write with `addr_i`=1 stores data bit 1 as the polarity (0x02 selects mode 2, 0x00 selects mode 0). From then on `sck_o` equals `phi_i` XOR the polarity.
- R3: A read with `addr_i`=1 returns bit 7 = busy, bit 1 = polarity, and 0 in all other bits.
- R4: After a data write (`addr_i`=0), the byte is loaded into the shift register on the next sampled falling edge of `phi_i`. `mosi_o` then shows bit 7 of the byte.
- R5: Each sampled rising edge of `phi_i` during a transfer shifts the register left by one place, MSB first. `mosi_o` then shows the next lower bit of the byte, and `miso_i` is captured into the LSB on that same edge.
- R6: After the eighth rising edge, a data-register read returns the eight MISO bits, first-sampled bit in bit 7. Further phase-clock edges leave this value unchanged.
- R7: `busy_o` rises on the cycle after a data write and stays high until the eighth rising edge of that transfer.
- R8: A write strobe held high for many cycles counts as a single write. The byte is loaded once and the transfer still ends after eight rising edges.
- R9: A polarity write clears the pending byte, the shift register, the bit count and the received byte. When it coincides with a falling edge that would load a pending byte, the clear takes priority and no transfer starts.
- R10: `data_io` is driven only while `cs_i` and `rd_i` are both high, and is high impedance otherwise. Strobes with `cs_i` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip enable, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| addr_i | input | 1 | Register select: 0 = data, 1 = polarity/status |
| data_io | inout | 8 | Bidirectional bus data |
| phi_i | input | 1 | Bus phase clock |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer pending or in progress |

## Verification
A polarity write and a falling edge of the phase clock can land in the same system-clock cycle while a byte is waiting to be loaded. In that case the clear must take priority over the load. The bench provokes this by lowering `phi_i` on the same cycle that it issues the polarity write. It then runs eight rising edges and expects `busy_o` to stay low, MOSI to stay low and the received byte to read 0x00. A second overlap is also exercised: a write strobe held high across a whole transfer. That transfer must still load once and end after eight shifts.

// File: rtl/spi_bus_pkg.sv
package spi_bus_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned POL_BIT = 1;
  localparam int unsigned BSY_BIT = 7;
  typedef enum logic {SEL_DATA = 1'b0, SEL_CFG = 1'b1} reg_sel_e;
endpackage

// File: rtl/spi_bus_decode.sv
module spi_bus_decode
  import spi_bus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic addr_i,
  output logic data_wr_o,
  output logic cfg_wr_o,
  output logic rd_en_o
);
  logic wr_q;
  logic wr_act;

  assign wr_act = cs_i & wr_i;

  // one pulse per strobe, however long it is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_act;
  end

  assign data_wr_o = wr_act & ~wr_q & (reg_sel_e'(addr_i) == SEL_DATA);
  assign cfg_wr_o  = wr_act & ~wr_q & (reg_sel_e'(addr_i) == SEL_CFG);
  assign rd_en_o   = cs_i & rd_i;
endmodule

// File: rtl/spi_phase_edge.sv
module spi_phase_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi_i,
  output logic rise_o,
  output logic fall_o
);
  logic phi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi_q <= 1'b0;
    else         phi_q <= phi_i;
  end

  assign rise_o = phi_i & ~phi_q;
  assign fall_o = ~phi_i & phi_q;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_req_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic          busy_o,
  output logic [DW-1:0] rx_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic          pend_q;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] rx_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_nxt;

  assign sh_nxt = {sh_q[DW-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else begin
      if (fall_i && pend_q) begin
        sh_q   <= hold_q;
        cnt_q  <= CW'(DW);
        pend_q <= 1'b0;
      end else if (rise_i && cnt_q != '0) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) rx_q <= sh_nxt;
      end
      // a new write re-arms the load even on a load cycle
      if (load_req_i) begin
        pend_q <= 1'b1;
        hold_q <= wdata_i;
      end
    end
  end

  assign mosi_o = sh_q[DW-1];
  assign busy_o = pend_q | (cnt_q != '0);
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_bus_master.sv
module spi_bus_master
  import spi_bus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             addr_i,
  inout  wire  [BUS_W-1:0] data_io,
  input  logic             phi_i,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             busy_o
);
  logic             data_wr, cfg_wr, rd_en;
  logic             phi_rise, phi_fall;
  logic             pol_q;
  logic [BUS_W-1:0] rx_byte;
  logic [BUS_W-1:0] cfg_rd;
  logic [BUS_W-1:0] rdata;

  spi_bus_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .data_wr_o(data_wr),
    .cfg_wr_o (cfg_wr),
    .rd_en_o  (rd_en)
  );

  spi_phase_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .phi_i (phi_i),
    .rise_o(phi_rise),
    .fall_o(phi_fall)
  );

  spi_shift_engine #(.DW(BUS_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_wr),
    .load_req_i(data_wr),
    .wdata_i   (data_io),
    .rise_i    (phi_rise),
    .fall_i    (phi_fall),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .busy_o    (busy_o),
    .rx_o      (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pol_q <= 1'b0;
    else if (cfg_wr) pol_q <= data_io[POL_BIT];
  end

  assign sck_o = phi_i ^ pol_q;

  always_comb begin
    cfg_rd          = '0;
    cfg_rd[POL_BIT] = pol_q;
    cfg_rd[BSY_BIT] = busy_o;
  end

  assign rdata   = (reg_sel_e'(addr_i) == SEL_CFG) ? cfg_rd : rx_byte;
  assign data_io = rd_en ? rdata : 'z;
endmodule

// File: rtl/spi_bus_master_chk.sv
module spi_bus_master_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          phi_i,
  input logic          sck_o,
  input logic          mosi_o,
  input logic          busy_o,
  input logic          data_wr,
  input logic          cfg_wr,
  input logic          phi_rise,
  input logic [DW-1:0] rx_byte
);
  // R2
  pol_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr |=> $stable(sck_o ^ phi_i));

  // R5
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi_i == $past(phi_i)) && !cfg_wr |=> $stable(mosi_o));

  // R7
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> busy_o);

  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(phi_rise || cfg_wr));

  // R6
  rx_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_byte) |-> ($fell(busy_o) || $past(cfg_wr)));
endmodule

bind spi_bus_master spi_bus_master_chk #(.DW(spi_bus_pkg::BUS_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .phi_i   (phi_i),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o),
  .busy_o  (busy_o),
  .data_wr (data_wr),
  .cfg_wr  (cfg_wr),
  .phi_rise(phi_rise),
  .rx_byte (rx_byte)
);

// File: tb/spi_bus_master_tb_top.sv
`timescale 1ns/1ps
module spi_bus_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic phi = 1'b0, miso = 1'b0;
  logic drv_en = 1'b0;
  logic [7:0] drv_val = 8'h00;
  wire  [7:0] bus;
  logic sck, mosi, busy;
  logic cur_pol = 1'b0;
  int   n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  assign bus = drv_en ? drv_val : 'z;

  spi_bus_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .data_io(bus), .phi_i(phi), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cfg(input logic b, input logic p);
    return {b, 5'b0, p, 1'b0};
  endfunction

  task automatic bus_write(input logic a, input logic [7:0] d, input int hold);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; drv_val = d; drv_en = 1'b1;
    repeat (hold) @(negedge clk);
    cs = 1'b0; wr = 1'b0; drv_en = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #2 v = bus;
    #1 cs = 1'b0; rd = 1'b0;
  endtask

  task automatic phi_set(input logic v);
    @(negedge clk);
    phi = v;
    @(negedge clk);
  endtask

  task automatic set_pol(input logic p);
    bus_write(1'b1, {6'b0, p, 1'b0}, 1);
    cur_pol = p;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input bit long_wr);
    logic [7:0] v;
    phi_set(1'b1);
    if (long_wr) begin
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = 1'b0; drv_val = tx; drv_en = 1'b1;
    end else begin
      bus_write(1'b0, tx, 1);
    end
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy after write", busy, 1);
    phi_set(1'b0);
    chk(mosi == tx[7], "R4 mosi after load", mosi, tx[7]);
    chk(sck == cur_pol, "R2 sck low phase", sck, cur_pol);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); miso = rx[7-k];
      phi_set(1'b1);
      chk(sck == ~cur_pol, "R2 sck high phase", sck, ~cur_pol);
      if (k < 7) begin
        chk(mosi == tx[6-k], long_wr ? "R8 mosi shift" : "R5 mosi shift", mosi, tx[6-k]);
        chk(busy == 1'b1, "R7 busy mid", busy, 1);
      end else begin
        chk(busy == 1'b0, long_wr ? "R8 busy end" : "R7 busy end", busy, 0);
      end
      phi_set(1'b0);
    end
    if (long_wr) begin
      @(negedge clk); cs = 1'b0; wr = 1'b0; drv_en = 1'b0;
    end
    miso = ~miso;
    phi_set(1'b1); phi_set(1'b0); phi_set(1'b1);
    chk(busy == 1'b0, "R8 no reload", busy, 0);
    bus_read(1'b0, v);
    chk(v == rx, "R6 rx byte", v, rx);
    bus_read(1'b1, v);
    chk(v == exp_cfg(1'b0, cur_pol), "R3 cfg read", v, exp_cfg(1'b0, cur_pol));
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240207));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(sck == phi, "R1 sck", sck, phi);
    bus_read(1'b0, v);
    chk(v == 8'h00, "R1 data", v, 0);
    bus_read(1'b1, v);
    chk(v == 8'h00, "R1 cfg", v, 0);

    // directed transfers, mode 0 then mode 2
    xfer(8'hA5, 8'h3C, 1'b0);
    set_pol(1'b1);
    bus_read(1'b1, v);
    chk(v == 8'h02, "R2 pol set", v, 8'h02);
    xfer(8'h81, 8'hFF, 1'b0);
    xfer(8'h00, 8'h01, 1'b1);
    set_pol(1'b0);

    // R3 busy visible in cfg read
    phi_set(1'b1);
    bus_write(1'b0, 8'hF0, 1);
    bus_read(1'b1, v);
    chk(v == 8'h80, "R3 busy bit", v, 8'h80);

    // R9 clear mid-transfer
    phi_set(1'b0);
    phi_set(1'b1); phi_set(1'b0); phi_set(1'b1);
    set_pol(1'b0);
    chk(busy == 1'b0, "R9 busy cleared", busy, 0);
    chk(mosi == 1'b0, "R9 shift cleared", mosi, 0);
    bus_read(1'b0, v);
    chk(v == 8'h00, "R9 rx cleared", v, 0);

    // R9 clear coincides with load edge
    xfer(8'h5A, 8'hC3, 1'b0);
    phi_set(1'b1);
    bus_write(1'b0, 8'hFF, 1);
    @(negedge clk);
    phi = 1'b0; cs = 1'b1; wr = 1'b1; addr = 1'b1; drv_val = 8'h00; drv_en = 1'b1;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; drv_en = 1'b0;
    chk(busy == 1'b0, "R9 clear beats load", busy, 0);
    chk(mosi == 1'b0, "R9 no load", mosi, 0);
    for (int k = 0; k < 8; k++) begin
      miso = 1'b1; phi_set(1'b1); phi_set(1'b0);
    end
    chk(busy == 1'b0, "R9 no transfer", busy, 0);
    bus_read(1'b0, v);
    chk(v == 8'h00, "R9 rx empty", v, 0);

    // R10 strobes without chip enable
    phi_set(1'b1);
    @(negedge clk);
    wr = 1'b1; addr = 1'b0; drv_val = 8'h77; drv_en = 1'b1;
    @(negedge clk); wr = 1'b0;
    phi_set(1'b0);
    chk(busy == 1'b0, "R10 write ignored", busy, 0);
    chk(mosi == 1'b0, "R10 no load", mosi, 0);
    @(negedge clk); rd = 1'b1; drv_val = 8'h5A;
    #2 chk(bus == 8'h5A, "R10 bus released", bus, 8'h5A);
    #1 rd = 1'b0; drv_en = 1'b0;

    // random transfers
    for (int i = 0; i < 40; i++) begin
      logic [7:0] tx, rx;
      tx = 8'($urandom);
      rx = 8'($urandom);
      if (($urandom % 4) == 0) set_pol(1'($urandom));
      xfer(tx, rx, 1'(($urandom % 5) == 0));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule